// File: doc/BRIEF.md
# Speed-selectable PHY-link data gearbox

This block sits between a parallel link-side data bus and the serial bit stream of a cable physical layer. The link side moves one word per system clock period (49.152 MHz in the target system). The serial side runs at two, four or eight bits per system period, depending on the speed of the current packet. A single bus therefore carries three serial rates while its parallel clock stays fixed. The design runs on one fast clock, `clk_i`, which is an exact multiple of the system clock (LANES times faster). The input `sys_ce_i` marks the last fast cycle of each system period and keeps the two clocks phase-aligned.

On transmit, a word is taken from the link bus on each system period in which `tx_valid_i` is high. In the following period it is shifted out one bit at a time, lowest lane first, with bit strobes spread evenly across that period. On receive, strobed serial bits are gathered into a parallel group. Each completed group is handed to the link side on a system-period boundary. If a packet ends in the middle of a group, the missing lanes are padded with zeros and the group is flagged.

Each direction fixes its lane count when its packet starts and keeps it until the packet ends. Encoding, clock recovery, line drivers and arbitration are outside this block.

Top module: `link_gearbox`

## Requirements
- R1: The 2-bit speed code selects the number of active lanes: 00 selects 2, 01 selects 4, 10 selects 8, and the reserved value 11 selects 2.
- R2: When `tx_valid_i` is high in a fast cycle with `sys_ce_i` high, the word on `tx_data_i` is captured. During the next system period (fast cycles 0..7 after that edge), exactly N strobes appear on `tx_bit_vld_o`, at fast cycles 0, 8/N, 2*8/N and so on. The strobe at index k carries bit k of the word, so lane 0 goes out first.
- R3: Transmit lanes at or above N are not sent. A system period that follows a capture edge with `tx_valid_i` low shows no strobe at all.
- R4: The transmit lane count is taken from `tx_speed_i` on the capture edge that starts a packet, meaning the previous period held no word. Changes to `tx_speed_i` while the packet continues have no effect.
- R5: On receive, while `rx_pkt_i` is high, each bit with `rx_bit_vld_i` high fills the next lane, starting at lane 0. When N bits have been gathered, the group is presented on `rx_data_o` with `rx_valid_o` high. This happens for exactly one system period, starting at the `sys_ce_i` edge that ends the period in which the last bit arrived.
- R6: Receive lanes at or above N read as zero on `rx_data_o`, and `rx_data_o` reads as zero whenever `rx_valid_o` is low.
- R7: The receive lane count is taken from `rx_speed_i` in the fast cycle where `rx_pkt_i` rises. Changes during the packet have no effect.
- R8: When `rx_pkt_i` falls with a partial group gathered, the group is padded with zeros in its missing lanes and delivered at the next `sys_ce_i` edge, with `rx_err_o` high for that system period. A group that completes normally is delivered with `rx_err_o` low.
- R9: While `rst_ni` is low, `tx_bit_o`, `tx_bit_vld_o`, `rx_data_o`, `rx_valid_o` and `rx_err_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock, LANES times the system clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sys_ce_i | input | 1 | High in the last fast cycle of each system period |
| tx_speed_i | input | 2 | Transmit speed code |
| tx_data_i | input | 8 | Link-side transmit word |
| tx_valid_i | input | 1 | Transmit packet framing, sampled with `sys_ce_i` |
| tx_bit_o | output | 1 | Serial transmit bit |
| tx_bit_vld_o | output | 1 | Strobe that qualifies `tx_bit_o` |
| rx_speed_i | input | 2 | Receive speed code |
| rx_bit_i | input | 1 | Recovered serial receive bit |
| rx_bit_vld_i | input | 1 | Strobe that qualifies `rx_bit_i` |
| rx_pkt_i | input | 1 | Receive packet framing on the serial side |
| rx_data_o | output | 8 | Link-side receive word |
| rx_valid_o | output | 1 | Receive word valid, one system period long |
| rx_err_o | output | 1 | Delivered word was a zero-padded partial group |

## Verification
The assertions assume that `sys_ce_i` is high exactly once every LANES fast cycles, so that the period phase counter reads its last value whenever the strobe arrives. They also assume that receive bits arrive no faster than N per system period, so that a finished group is never overwritten before it is handed over. The stimulus stays within these limits because every system period is produced by one task. That task drives eight fast cycles with `sys_ce_i` high only on the last one. It places at most N receive bits, each on a fast cycle that is a multiple of 8/N. Speed-code changes, a partial final group and the reserved speed code all fall inside these same limits.

// File: rtl/link_gearbox_pkg.sv
package link_gearbox_pkg;
  localparam int unsigned LANES_MAX = 8;
  localparam int unsigned SEL_W     = 2;

  typedef logic [1:0]       speed_t;
  typedef logic [SEL_W-1:0] lsel_t;   // log2 of active lane count

  function automatic lsel_t speed_to_lsel(input speed_t code);
    case (code)
      2'b01:   return lsel_t'(2);
      2'b10:   return lsel_t'(3);
      default: return lsel_t'(1);  // 00 and reserved 11
    endcase
  endfunction
endpackage

// File: rtl/link_gearbox_tx.sv
module link_gearbox_tx
  import link_gearbox_pkg::*;
#(
  parameter int unsigned LANES = LANES_MAX,
  localparam int unsigned PW   = $clog2(LANES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sys_ce_i,
  input  speed_t           speed_i,
  input  logic [LANES-1:0] data_i,
  input  logic             valid_i,
  output logic             bit_o,
  output logic             bit_vld_o
);
  logic             busy_q;
  lsel_t            lsel_q;
  logic [LANES-1:0] sh_q;
  logic [PW-1:0]    ph_q;
  logic [PW-1:0]    sft, step_mask, idx;
  logic [PW:0]      lanes_w;

  always_comb begin
    sft       = PW'(PW) - PW'(lsel_q);
    step_mask = (PW'(1) << sft) - PW'(1);
    idx       = ph_q >> sft;
    lanes_w   = (PW+1)'(1) << lsel_q;
  end

  assign bit_vld_o = busy_q & ((ph_q & step_mask) == '0);
  assign bit_o     = bit_vld_o & sh_q[idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      lsel_q <= speed_to_lsel(2'b00);
      sh_q   <= '0;
      ph_q   <= '0;
    end else if (sys_ce_i) begin
      ph_q   <= '0;
      busy_q <= valid_i;
      if (valid_i) sh_q <= data_i;
      // lane count fixed at packet start
      if (valid_i && !busy_q) lsel_q <= speed_to_lsel(speed_i);
    end else begin
      ph_q <= ph_q + PW'(1);
    end
  end

  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       seen_q <= 1'b0;
    else if (sys_ce_i) seen_q <= 1'b1;
  end

  AST_SYS_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_ce_i && seen_q) |-> (ph_q == PW'(LANES-1))); // R2
  AST_TX_LANES_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> $stable(lsel_q)); // R4
  AST_TX_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_vld_o |-> ({1'b0, idx} < lanes_w)); // R3
endmodule

// File: rtl/link_gearbox_rx.sv
module link_gearbox_rx
  import link_gearbox_pkg::*;
#(
  parameter int unsigned LANES = LANES_MAX,
  localparam int unsigned PW   = $clog2(LANES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sys_ce_i,
  input  speed_t           speed_i,
  input  logic             bit_i,
  input  logic             bit_vld_i,
  input  logic             pkt_i,
  output logic [LANES-1:0] data_o,
  output logic             valid_o,
  output logic             err_o
);
  logic             pkt_q;
  lsel_t            lsel_q, lsel_c;
  logic [PW-1:0]    cnt_q;
  logic [LANES-1:0] acc_q, acc_n;
  logic [LANES-1:0] hold_q;
  logic             hold_vld_q, hold_err_q;
  logic [PW:0]      lanes_c, lanes_q_w;
  logic             take, last, flush, set;
  logic [LANES-1:0] set_data, nxt_data;
  logic             set_err, nxt_vld, nxt_err;

  always_comb begin
    lsel_c    = (pkt_i && !pkt_q) ? speed_to_lsel(speed_i) : lsel_q;
    lanes_c   = (PW+1)'(1) << lsel_c;
    lanes_q_w = (PW+1)'(1) << lsel_q;
    take      = pkt_i & bit_vld_i;
    acc_n     = acc_q | (LANES'(bit_i) << cnt_q);
    last      = take && (cnt_q == (lanes_c[PW-1:0] - PW'(1)));
    flush     = pkt_q && !pkt_i && (cnt_q != '0);
    set       = last || flush;
    set_data  = last ? acc_n : acc_q;
    set_err   = !last;
    nxt_vld   = set || hold_vld_q;
    nxt_data  = set ? set_data : (hold_vld_q ? hold_q : '0);
    nxt_err   = set ? set_err : (hold_vld_q & hold_err_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pkt_q  <= 1'b0;
      lsel_q <= speed_to_lsel(2'b00);
      cnt_q  <= '0;
      acc_q  <= '0;
    end else begin
      pkt_q  <= pkt_i;
      lsel_q <= lsel_c;
      if (take) begin
        if (last) begin
          acc_q <= '0;
          cnt_q <= '0;
        end else begin
          acc_q <= acc_n;
          cnt_q <= cnt_q + PW'(1);
        end
      end else if (flush) begin
        acc_q <= '0;
        cnt_q <= '0;
      end
    end
  end

  // hand-over to the system-clock side, with bypass when a group lands on the boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q     <= '0;
      hold_vld_q <= 1'b0;
      hold_err_q <= 1'b0;
      data_o     <= '0;
      valid_o    <= 1'b0;
      err_o      <= 1'b0;
    end else if (sys_ce_i) begin
      data_o     <= nxt_data;
      valid_o    <= nxt_vld;
      err_o      <= nxt_err;
      hold_vld_q <= 1'b0;
    end else if (set) begin
      hold_q     <= set_data;
      hold_vld_q <= 1'b1;
      hold_err_q <= set_err;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set |-> (!hold_vld_q || sys_ce_i)); // R5
  AST_RX_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, cnt_q} < lanes_q_w)); // R7
  AST_RX_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((acc_q >> lanes_q_w) == '0)); // R6
  AST_RX_DELIVER_ON_CE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(sys_ce_i)); // R5
  AST_RX_ERR_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> valid_o); // R8
endmodule

// File: rtl/link_gearbox.sv
module link_gearbox
  import link_gearbox_pkg::*;
#(
  parameter int unsigned LANES = LANES_MAX
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sys_ce_i,
  input  logic [1:0]       tx_speed_i,
  input  logic [LANES-1:0] tx_data_i,
  input  logic             tx_valid_i,
  output logic             tx_bit_o,
  output logic             tx_bit_vld_o,
  input  logic [1:0]       rx_speed_i,
  input  logic             rx_bit_i,
  input  logic             rx_bit_vld_i,
  input  logic             rx_pkt_i,
  output logic [LANES-1:0] rx_data_o,
  output logic             rx_valid_o,
  output logic             rx_err_o
);
  link_gearbox_tx #(.LANES(LANES)) u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sys_ce_i  (sys_ce_i),
    .speed_i   (tx_speed_i),
    .data_i    (tx_data_i),
    .valid_i   (tx_valid_i),
    .bit_o     (tx_bit_o),
    .bit_vld_o (tx_bit_vld_o)
  );

  link_gearbox_rx #(.LANES(LANES)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sys_ce_i  (sys_ce_i),
    .speed_i   (rx_speed_i),
    .bit_i     (rx_bit_i),
    .bit_vld_i (rx_bit_vld_i),
    .pkt_i     (rx_pkt_i),
    .data_o    (rx_data_o),
    .valid_o   (rx_valid_o),
    .err_o     (rx_err_o)
  );
endmodule

// File: tb/link_gearbox_tb.sv
module link_gearbox_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       sys_ce_i;
  logic [1:0] tx_speed_i, rx_speed_i;
  logic [7:0] tx_data_i;
  logic       tx_valid_i;
  logic       tx_bit_o, tx_bit_vld_o;
  logic       rx_bit_i, rx_bit_vld_i, rx_pkt_i;
  logic [7:0] rx_data_o;
  logic       rx_valid_o, rx_err_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk_i = ~clk_i;

  link_gearbox u_dut (
    .clk_i, .rst_ni, .sys_ce_i, .tx_speed_i, .tx_data_i, .tx_valid_i,
    .tx_bit_o, .tx_bit_vld_o, .rx_speed_i, .rx_bit_i, .rx_bit_vld_i,
    .rx_pkt_i, .rx_data_o, .rx_valid_o, .rx_err_o
  );

  logic [7:0] tx_cap, tx_pos, snap_d;
  int         tx_cnt;
  logic       snap_v, snap_e;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int lanes_of(input logic [1:0] s);
    return (s == 2'b01) ? 4 : (s == 2'b10) ? 8 : 2;
  endfunction

  function automatic logic [7:0] pos_mask(input int n);
    logic [7:0] m = '0;
    for (int k = 0; k < 8; k += 8 / n) m[k] = 1'b1;
    return m;
  endfunction

  function automatic logic [7:0] lane_mask(input int n);
    return 8'((1 << n) - 1);
  endfunction

  // one system period: eight fast cycles, sys_ce on the last
  task automatic run_period(input logic tv, input logic [7:0] td, input logic [1:0] ts,
                            input logic rp, input logic [7:0] rd, input int rn,
                            input int rstep, input logic [1:0] rs);
    tx_cap = '0; tx_pos = '0; tx_cnt = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      if (i == 0) begin
        snap_v = rx_valid_o; snap_d = rx_data_o; snap_e = rx_err_o;
      end
      if (tx_bit_vld_o) begin
        if (tx_cnt < 8) tx_cap[tx_cnt] = tx_bit_o;
        tx_pos[i] = 1'b1;
        tx_cnt++;
      end
      sys_ce_i     = (i == 7);
      tx_valid_i   = tv;
      tx_data_i    = td;
      tx_speed_i   = ts;
      rx_pkt_i     = rp;
      rx_speed_i   = rs;
      rx_bit_vld_i = rp && (i % rstep == 0) && (i / rstep < rn);
      rx_bit_i     = rx_bit_vld_i ? rd[i / rstep] : 1'b0;
    end
  endtask

  task automatic idle_period();
    run_period(1'b0, 8'h00, 2'b00, 1'b0, 8'h00, 0, 1, 2'b00);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] prev, d;
    int n;
    rst_ni = 1'b0; sys_ce_i = 1'b0; tx_speed_i = '0; rx_speed_i = '0;
    tx_data_i = '0; tx_valid_i = 1'b0; rx_bit_i = 1'b0; rx_bit_vld_i = 1'b0; rx_pkt_i = 1'b0;
    repeat (4) @(negedge clk_i);
    check({tx_bit_o, tx_bit_vld_o, rx_valid_o, rx_err_o} == 4'b0 && rx_data_o == 8'h00,
          "R9 reset outputs", {tx_bit_o, tx_bit_vld_o, rx_valid_o, rx_err_o, rx_data_o}, 0);
    rst_ni = 1'b1;
    idle_period();
    idle_period();

    // sweep every speed code, three-word packets in both directions
    for (int s = 0; s < 4; s++) begin
      n = lanes_of(2'(s));
      prev = '0;
      for (int w = 0; w < 4; w++) begin
        d = 8'(8'hA5 ^ (s * 37 + w * 91));
        run_period(w < 3, d, 2'(s), w < 3, d, n, 8 / n, 2'(s));
        if (w == 0) begin
          check(tx_cnt == 0, "R3 no strobe without word", tx_cnt, 0);
          check(snap_v == 1'b0 && snap_d == 8'h00, "R6 idle rx output zero", {snap_v, snap_d}, 0);
        end else begin
          check(tx_cnt == n, "R1 lane count from speed code", tx_cnt, n);
          check(tx_pos == pos_mask(n), "R2 strobe spacing", tx_pos, pos_mask(n));
          check(tx_cap == (prev & lane_mask(n)), "R2 R3 serial bit order", tx_cap, prev & lane_mask(n));
          check(snap_v == 1'b1, "R5 rx group delivered", snap_v, 1);
          check(snap_d == (prev & lane_mask(n)), "R5 R6 rx lanes", snap_d, prev & lane_mask(n));
          check(snap_e == 1'b0, "R8 full group no error", snap_e, 0);
        end
        prev = d;
      end
    end
    idle_period();
    check(snap_v == 1'b0, "R5 valid lasts one period", snap_v, 0);
    check(tx_cnt == 0, "R3 quiet after packet", tx_cnt, 0);

    // speed change inside a packet is ignored
    run_period(1'b1, 8'h96, 2'b00, 1'b1, 8'h96, 2, 4, 2'b00);
    run_period(1'b1, 8'h6A, 2'b10, 1'b1, 8'h6A, 2, 4, 2'b10);
    check(tx_cnt == 2 && tx_cap == 8'h02, "R4 first word at 2 lanes", {tx_cnt[3:0], tx_cap}, 12'h202);
    run_period(1'b0, 8'h00, 2'b10, 1'b0, 8'h00, 0, 4, 2'b10);
    check(tx_cnt == 2 && tx_cap == 8'h02, "R4 speed held mid packet", {tx_cnt[3:0], tx_cap}, 12'h202);
    check(snap_v == 1'b1 && snap_d == 8'h02, "R7 rx speed held mid packet", {snap_v, snap_d}, 9'h102);
    idle_period();
    check(tx_cnt == 0, "R3 quiet after speed test", tx_cnt, 0);
    idle_period();

    // partial final group at 8 lanes
    run_period(1'b0, 8'h00, 2'b10, 1'b1, 8'h3C, 8, 1, 2'b10);
    run_period(1'b0, 8'h00, 2'b10, 1'b1, 8'hFF, 3, 1, 2'b10);
    check(snap_v && snap_d == 8'h3C && !snap_e, "R5 full 8-lane group", {snap_v, snap_e, snap_d}, 10'h23C);
    run_period(1'b0, 8'h00, 2'b10, 1'b0, 8'h00, 0, 1, 2'b10);
    check(!snap_v, "R8 partial not yet delivered", snap_v, 0);
    idle_period();
    check(snap_v && snap_e && snap_d == 8'h07, "R8 padded partial flagged", {snap_v, snap_e, snap_d}, 10'h307);
    idle_period();
    check(!snap_v && !snap_e && snap_d == 8'h00, "R8 error lasts one period", {snap_v, snap_e, snap_d}, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule